// File: doc/BRIEF.md
# Segmented Virtual Address Translator with Paired-Page TLB

This block turns a 32-bit virtual address into a physical address for one access per cycle. The upper three address bits pick a segment. Each segment is either translated directly by subtracting a fixed base, or looked up in a small fully associative translation buffer. Each segment also checks the current privilege level (kernel, supervisor or user). An access from a privilege level the segment does not allow is refused with a bad-address result.

Each buffer entry describes a pair of adjacent 4 KB pages, an even one and an odd one, that share a tag. Each page of the pair has its own frame number, valid bit and dirty bit. An entry matches either through a global bit or through an 8-bit address-space identifier. The lookup is purely combinational. The result code tells the surrounding pipeline whether the access may proceed, or which kind of fault it must raise. Entries are loaded through a single indexed write port. A load becomes visible to lookups on the cycle after the clock edge that captures it.

Top module: `addr_xlate`

## Requirements
- R1: A synchronous active-low reset empties every entry. Until an entry is loaded, every lookup in a mapped segment that privilege allows returns the no-match code (2).
- R2: Addresses 0x00000000–0x7FFFFFFF are allowed at every privilege level and are looked up in the buffer. When `lk_errlvl` is 1 they bypass the buffer instead: physical equals virtual, writable is 1, and the result is match (0).
- R3: `lk_mode` encodes 0 kernel, 1 supervisor, 2 or 3 user. In kernel mode, 0x80000000–0x9FFFFFFF translates to the address minus 0x80000000, and 0xA0000000–0xBFFFFFFF translates to the address minus 0xA0000000. Both have writable 1 and result 0. In any other mode, these ranges return bad-address (1).
- R4: 0xC0000000–0xDFFFFFFF is looked up in the buffer for kernel or supervisor mode and is bad-address (1) for user mode. 0xE0000000–0xFFFFFFFF is looked up in the buffer for kernel mode only and is bad-address otherwise.
- R5: An entry hits when its stored 19-bit page-pair tag equals address bits 31:13 and, in addition, its global bit is 1 or its 8-bit identifier equals `lk_asid`.
- R6: Address bit 12 chooses the odd half (1) or the even half (0) of the hit entry: its frame number, valid bit and dirty bit.
- R7: A hit whose chosen valid bit is 0 returns invalid (3).
- R8: A hit with the valid bit set, `lk_write` at 1 and the dirty bit at 0 returns dirty (4). The same hit with `lk_write` at 0 returns match with writable 0.
- R9: A successful hit returns the chosen 20-bit frame number joined with address bits 11:0 as the physical address. Writable equals the chosen dirty bit.
- R10: When several entries hit, the lowest-indexed one decides the result.
- R11: Whenever the result is not match (0), the physical address is 0 and writable is 0.
- R12: When `tw_en` is 1, entry `tw_idx` is replaced at the clock edge. Lookups in that same cycle still see the old contents, and lookups from the next cycle see the new ones. The result code is 3 bits wide: 0 match, 1 bad address, 2 no match, 3 invalid, 4 dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a store |
| lk_mode | input | 2 | Privilege level: 0 kernel, 1 supervisor, 2/3 user |
| lk_errlvl | input | 1 | Error-level status: low segment bypasses the buffer |
| lk_asid | input | 8 | Current address-space identifier |
| tw_en | input | 1 | Load an entry this cycle |
| tw_idx | input | 4 | Entry to load |
| tw_vpn2 | input | 19 | Page-pair tag (virtual address bits 31:13) |
| tw_asid | input | 8 | Identifier stored with the entry |
| tw_global | input | 1 | Entry matches every identifier |
| tw_pfn_even | input | 20 | Frame number of the even page |
| tw_valid_even | input | 1 | Even page valid |
| tw_dirty_even | input | 1 | Even page writable |
| tw_pfn_odd | input | 20 | Frame number of the odd page |
| tw_valid_odd | input | 1 | Odd page valid |
| tw_dirty_odd | input | 1 | Odd page writable |
| xl_paddr | output | 32 | Physical address |
| xl_writable | output | 1 | Page may be written |
| xl_result | output | 3 | Result code |

## Verification
Stored state lives only in the entries, so a corrupted tag, identifier, half or flag bit shows up in the very next lookup that touches that entry. It appears as a wrong result code, a wrong frame number or a wrong writable flag, in the same cycle as the lookup. A load that lands in the wrong slot, or too early, shows up either as a stale translation one cycle after the load or as a lost priority between overlapping entries. The bench keeps an independent model of all sixteen entries. It compares every output on every cycle over directed overlaps and several thousand random loads and lookups, so such a fault is reported within the cycle it first becomes observable.

// File: rtl/xlate_pkg.sv
// Package: shared encodings for the address translator.
// Assumes a 32-bit virtual space split into eight 512 MB regions by bits 31:29.
package xlate_pkg;

    // Result classification returned with every lookup
    typedef enum logic [2:0] {
        XR_MATCH    = 3'd0,
        XR_BADADDR  = 3'd1,
        XR_NOMATCH  = 3'd2,
        XR_INVALID  = 3'd3,
        XR_DIRTY    = 3'd4
    } xl_res_e;

    // Privilege level as presented on lk_mode
    typedef enum logic [1:0] {
        PM_KERNEL   = 2'd0,
        PM_SUPER    = 2'd1,
        PM_USER     = 2'd2,
        PM_USER_ALT = 2'd3
    } priv_e;

    // Segment kind decoded from the top address bits
    typedef enum logic [2:0] {
        SEG_LOW_MAP,
        SEG_KDIR_CACHED,
        SEG_KDIR_UNCACHED,
        SEG_SUPER_MAP,
        SEG_KERN_MAP
    } seg_e;

endpackage

// File: rtl/xlate_seg_decode.sv
// Segment decoder: classifies the virtual address by region, applies the
// privilege rule of that region, and computes the direct translation for
// regions that bypass the buffer. Assumes VA_W is 32 (regions use bits 31:29).
module xlate_seg_decode
    import xlate_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      mode,
    input  logic            errlvl,
    output logic            allowed,
    output logic            use_tlb,
    output logic [PA_W-1:0] direct_paddr
);

    localparam int REGION_LSB = VA_W - 3;

    seg_e  seg;
    priv_e pm;
    logic  is_kernel;
    logic  is_super;

    assign pm        = priv_e'(mode);
    assign is_kernel = (pm == PM_KERNEL);
    assign is_super  = (pm == PM_SUPER);

    // Region classification from the three top address bits
    always_comb begin
        unique case (vaddr[VA_W-1:REGION_LSB])
            3'd4:    seg = SEG_KDIR_CACHED;
            3'd5:    seg = SEG_KDIR_UNCACHED;
            3'd6:    seg = SEG_SUPER_MAP;
            3'd7:    seg = SEG_KERN_MAP;
            default: seg = SEG_LOW_MAP;
        endcase
    end

    // Privilege gate, buffer use and direct address per region
    always_comb begin
        allowed      = 1'b0;
        use_tlb      = 1'b0;
        direct_paddr = '0;
        unique case (seg)
            SEG_LOW_MAP: begin
                allowed = 1'b1;
                use_tlb = !errlvl;
                if (errlvl) direct_paddr = PA_W'(vaddr);
            end
            SEG_KDIR_CACHED, SEG_KDIR_UNCACHED: begin
                allowed      = is_kernel;
                direct_paddr = PA_W'(vaddr[REGION_LSB-1:0]);
            end
            SEG_SUPER_MAP: begin
                allowed = is_kernel || is_super;
                use_tlb = 1'b1;
            end
            default: begin
                allowed = is_kernel;
                use_tlb = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/xlate_tlb_entry.sv
// One buffer entry: holds a page-pair tag, identifier, global flag and two
// page halves packed as {pfn, valid, dirty}. Compares itself against the
// lookup and presents the half chosen by the page-select bit.
// Assumes the write select is already decoded for this entry.
module xlate_tlb_entry #(
    parameter int TAG_W  = 19,
    parameter int ASID_W = 8,
    parameter int HALF_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [HALF_W-1:0] wr_even,
    input  logic [HALF_W-1:0] wr_odd,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_odd,
    output logic              hit,
    output logic [HALF_W-1:0] half_out
);

    logic              used_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ASID_W-1:0] asid_q;
    logic              glob_q;
    logic [HALF_W-1:0] even_q;
    logic [HALF_W-1:0] odd_q;

    // Entry storage: cleared by reset, replaced when selected for writing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
            tag_q  <= '0;
            asid_q <= '0;
            glob_q <= 1'b0;
            even_q <= '0;
            odd_q  <= '0;
        end else if (wr_sel) begin
            used_q <= 1'b1;
            tag_q  <= wr_tag;
            asid_q <= wr_asid;
            glob_q <= wr_global;
            even_q <= wr_even;
            odd_q  <= wr_odd;
        end
    end

    // Tag and identifier compare, then pick the addressed half
    always_comb begin
        hit      = used_q && (tag_q == lk_tag) && (glob_q || (asid_q == lk_asid));
        half_out = lk_odd ? odd_q : even_q;
    end

endmodule

// File: rtl/xlate_hit_select.sv
// Priority selector: among all hitting entries, forwards the page half of
// the lowest-indexed one. Assumes half_bus holds entry i at slice i.
module xlate_hit_select #(
    parameter int ENTRIES = 16,
    parameter int HALF_W  = 22
) (
    input  logic [ENTRIES-1:0]        hit_vec,
    input  logic [ENTRIES*HALF_W-1:0] half_bus,
    output logic                      any_hit,
    output logic [HALF_W-1:0]         sel_half
);

    // Scan from the top so that the lowest hitting index is written last
    always_comb begin
        sel_half = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_half = half_bus[i*HALF_W +: HALF_W];
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/addr_xlate.sv
// Address translator top: segment decode and privilege check, sixteen-entry
// paired-page buffer with indexed write port, and final classification into
// one of five result codes. Lookups are combinational; loads take effect at
// the clock edge. Assumes a 32-bit virtual space and 4 KB pages.
module addr_xlate
    import xlate_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int ENTRIES   = 16,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int TAG_W    = VA_W - PAGE_BITS - 1,
    localparam int PFN_W    = PA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic [1:0]        lk_mode,
    input  logic              lk_errlvl,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [TAG_W-1:0]  tw_vpn2,
    input  logic [ASID_W-1:0] tw_asid,
    input  logic              tw_global,
    input  logic [PFN_W-1:0]  tw_pfn_even,
    input  logic              tw_valid_even,
    input  logic              tw_dirty_even,
    input  logic [PFN_W-1:0]  tw_pfn_odd,
    input  logic              tw_valid_odd,
    input  logic              tw_dirty_odd,
    output logic [PA_W-1:0]   xl_paddr,
    output logic              xl_writable,
    output logic [2:0]        xl_result
);

    localparam int HALF_W = PFN_W + 2;

    logic                      seg_allowed;
    logic                      seg_use_tlb;
    logic [PA_W-1:0]           seg_direct;
    logic [HALF_W-1:0]         wr_even;
    logic [HALF_W-1:0]         wr_odd;
    logic [ENTRIES-1:0]        hit_vec;
    logic [ENTRIES*HALF_W-1:0] half_bus;
    logic                      any_hit;
    logic [HALF_W-1:0]         sel_half;
    logic [PFN_W-1:0]          sel_pfn;
    logic                      sel_valid;
    logic                      sel_dirty;
    xl_res_e                   res;

    xlate_seg_decode #(
        .VA_W (VA_W),
        .PA_W (PA_W)
    ) u_seg (
        .vaddr        (lk_vaddr),
        .mode         (lk_mode),
        .errlvl       (lk_errlvl),
        .allowed      (seg_allowed),
        .use_tlb      (seg_use_tlb),
        .direct_paddr (seg_direct)
    );

    assign wr_even = {tw_pfn_even, tw_valid_even, tw_dirty_even};
    assign wr_odd  = {tw_pfn_odd,  tw_valid_odd,  tw_dirty_odd};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        xlate_tlb_entry #(
            .TAG_W  (TAG_W),
            .ASID_W (ASID_W),
            .HALF_W (HALF_W)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (tw_en && (tw_idx == IDX_W'(e))),
            .wr_tag    (tw_vpn2),
            .wr_asid   (tw_asid),
            .wr_global (tw_global),
            .wr_even   (wr_even),
            .wr_odd    (wr_odd),
            .lk_tag    (lk_vaddr[VA_W-1:PAGE_BITS+1]),
            .lk_asid   (lk_asid),
            .lk_odd    (lk_vaddr[PAGE_BITS]),
            .hit       (hit_vec[e]),
            .half_out  (half_bus[e*HALF_W +: HALF_W])
        );
    end

    xlate_hit_select #(
        .ENTRIES (ENTRIES),
        .HALF_W  (HALF_W)
    ) u_sel (
        .hit_vec  (hit_vec),
        .half_bus (half_bus),
        .any_hit  (any_hit),
        .sel_half (sel_half)
    );

    assign {sel_pfn, sel_valid, sel_dirty} = sel_half;

    // Classification: privilege, bypass, miss, invalid, dirty, then success
    always_comb begin
        xl_paddr    = '0;
        xl_writable = 1'b0;
        res         = XR_MATCH;
        if (!seg_allowed) begin
            res = XR_BADADDR;
        end else if (!seg_use_tlb) begin
            xl_paddr    = seg_direct;
            xl_writable = 1'b1;
        end else if (!any_hit) begin
            res = XR_NOMATCH;
        end else if (!sel_valid) begin
            res = XR_INVALID;
        end else if (lk_write && !sel_dirty) begin
            res = XR_DIRTY;
        end else begin
            xl_paddr    = {sel_pfn, lk_vaddr[PAGE_BITS-1:0]};
            xl_writable = sel_dirty;
        end
        xl_result = res;
    end

endmodule

// File: rtl/addr_xlate_chk.sv
// Checker for the address translator: port-level properties of the result
// classification, attached to every instance by the bind below.
// Assumes the 32-bit region layout of the translator.
module addr_xlate_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_write,
    input logic [1:0]      lk_mode,
    input logic            lk_errlvl,
    input logic            tw_en,
    input logic [PA_W-1:0] xl_paddr,
    input logic            xl_writable,
    input logic [2:0]      xl_result
);

    logic seen_load;
    logic mapped_seg;

    // Remembers whether any entry has been loaded since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_load <= 1'b0;
        else if (tw_en) seen_load <= 1'b1;
    end

    assign mapped_seg = (!lk_vaddr[VA_W-1] && !lk_errlvl) ||
                        (lk_vaddr[VA_W-1:VA_W-2] == 2'b11);

    // R1
    empty_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_load && mapped_seg && xl_result != 3'd1) |-> xl_result == 3'd2);

    // R2
    errlvl_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_errlvl && !lk_vaddr[VA_W-1]) |->
        (xl_result == 3'd0 && xl_writable && xl_paddr == PA_W'(lk_vaddr)));

    // R3
    kdirect_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mode == 2'd0 && lk_vaddr[VA_W-1:VA_W-2] == 2'b10) |->
        (xl_result == 3'd0 && xl_writable &&
         xl_paddr == PA_W'(lk_vaddr[VA_W-4:0])));

    // R3
    kdirect_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mode != 2'd0 && lk_vaddr[VA_W-1:VA_W-2] == 2'b10) |-> xl_result == 3'd1);

    // R4
    user_high_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mode[1] && lk_vaddr[VA_W-1:VA_W-2] == 2'b11) |-> xl_result == 3'd1);

    // R4
    super_top_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mode == 2'd1 && lk_vaddr[VA_W-1:VA_W-3] == 3'b111) |-> xl_result == 3'd1);

    // R8
    store_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_write && xl_result == 3'd0) |-> xl_writable);

    // R11
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_result != 3'd0) |-> (xl_paddr == '0 && !xl_writable));

    // R12
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_result <= 3'd4);

endmodule

bind addr_xlate addr_xlate_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_vaddr    (lk_vaddr),
    .lk_write    (lk_write),
    .lk_mode     (lk_mode),
    .lk_errlvl   (lk_errlvl),
    .tw_en       (tw_en),
    .xl_paddr    (xl_paddr),
    .xl_writable (xl_writable),
    .xl_result   (xl_result)
);

// File: tb/addr_xlate_tb.sv
// Bench: behavioural model of sixteen paired-page entries, compared with the
// translator on every cycle, plus directed checks with fixed expectations.
module addr_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic [1:0]  lk_mode = 2'd0;
    logic        lk_errlvl = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_idx = '0;
    logic [18:0] tw_vpn2 = '0;
    logic [7:0]  tw_asid = '0;
    logic        tw_global = 1'b0;
    logic [19:0] tw_pfn_even = '0;
    logic        tw_valid_even = 1'b0;
    logic        tw_dirty_even = 1'b0;
    logic [19:0] tw_pfn_odd = '0;
    logic        tw_valid_odd = 1'b0;
    logic        tw_dirty_odd = 1'b0;
    logic [31:0] xl_paddr;
    logic        xl_writable;
    logic [2:0]  xl_result;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    // model state
    bit          m_used [16];
    int unsigned m_tag  [16];
    int unsigned m_asid [16];
    bit          m_glob [16];
    int unsigned m_pfn  [16][2];
    bit          m_val  [16][2];
    bit          m_dir  [16][2];

    always #4 clk = ~clk;

    addr_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
        .lk_mode(lk_mode), .lk_errlvl(lk_errlvl), .lk_asid(lk_asid),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_vpn2(tw_vpn2), .tw_asid(tw_asid),
        .tw_global(tw_global), .tw_pfn_even(tw_pfn_even),
        .tw_valid_even(tw_valid_even), .tw_dirty_even(tw_dirty_even),
        .tw_pfn_odd(tw_pfn_odd), .tw_valid_odd(tw_valid_odd),
        .tw_dirty_odd(tw_dirty_odd), .xl_paddr(xl_paddr),
        .xl_writable(xl_writable), .xl_result(xl_result)
    );

    // model update on the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_used[i] = 1'b0;
        end else if (tw_en) begin
            m_used[tw_idx]    = 1'b1;
            m_tag[tw_idx]     = tw_vpn2;
            m_asid[tw_idx]    = tw_asid;
            m_glob[tw_idx]    = tw_global;
            m_pfn[tw_idx][0]  = tw_pfn_even;
            m_val[tw_idx][0]  = tw_valid_even;
            m_dir[tw_idx][0]  = tw_dirty_even;
            m_pfn[tw_idx][1]  = tw_pfn_odd;
            m_val[tw_idx][1]  = tw_valid_odd;
            m_dir[tw_idx][1]  = tw_dirty_odd;
        end
    end

    task automatic model(output logic [31:0] pa, output logic wr, output logic [2:0] rc);
        int unsigned va   = lk_vaddr;
        int unsigned top  = va >> 29;
        bit kern  = (lk_mode == 2'd0);
        bit sup   = (lk_mode == 2'd1);
        bit ok;
        bit look  = 1'b1;
        int found = -1;
        int h     = (va >> 12) & 1;
        pa = 0; wr = 0; rc = 3'd0;
        if (top < 4) ok = 1'b1;
        else if (top == 6) ok = kern || sup;
        else ok = kern;
        if (!ok) begin rc = 3'd1; return; end
        if (top < 4 && lk_errlvl) begin pa = va; wr = 1; return; end
        if (top == 4) begin pa = va - 32'h8000_0000; wr = 1; look = 0; end
        if (top == 5) begin pa = va - 32'hA000_0000; wr = 1; look = 0; end
        if (!look) return;
        for (int i = 0; i < 16; i++)
            if (found < 0 && m_used[i] && m_tag[i] == (va >> 13) &&
                (m_glob[i] || m_asid[i] == lk_asid)) found = i;
        if (found < 0) rc = 3'd2;
        else if (!m_val[found][h]) rc = 3'd3;
        else if (lk_write && !m_dir[found][h]) rc = 3'd4;
        else begin
            pa = (m_pfn[found][h] << 12) | (va & 32'hFFF);
            wr = m_dir[found][h];
        end
    endtask

    task automatic check(input string tag, input logic [31:0] pa, input logic wr,
                         input logic [2:0] rc);
        checks++;
        if (xl_paddr !== pa || xl_writable !== wr || xl_result !== rc) begin
            fails++;
            $display("FAIL %s va=%h: got pa=%h wr=%0b rc=%0d exp pa=%h wr=%0b rc=%0d",
                     tag, lk_vaddr, xl_paddr, xl_writable, xl_result, pa, wr, rc);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] pa; logic wr; logic [2:0] rc;
        if (rst_n && cmp_on) begin
            model(pa, wr, rc);
            check("R9 model", pa, wr, rc);
        end
    end

    task automatic look(input logic [31:0] va, input logic w, input logic [1:0] md,
                        input logic [7:0] asid, input logic erl);
        @(posedge clk); #1;
        lk_vaddr = va; lk_write = w; lk_mode = md; lk_asid = asid; lk_errlvl = erl;
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] idx, input logic [18:0] tg, input logic [7:0] as,
                        input logic g, input logic [19:0] pe, input logic ve, input logic de,
                        input logic [19:0] po, input logic vo, input logic dd);
        @(posedge clk); #1;
        tw_en = 1; tw_idx = idx; tw_vpn2 = tg; tw_asid = as; tw_global = g;
        tw_pfn_even = pe; tw_valid_even = ve; tw_dirty_even = de;
        tw_pfn_odd = po; tw_valid_odd = vo; tw_dirty_odd = dd;
        @(posedge clk); #1;
        tw_en = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        lk_vaddr = 32'h0000_1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset empty", 32'h0, 1'b0, 3'd2);
        @(posedge clk); #1; rst_n = 1'b1;
        cmp_on = 1'b1;

        look(32'h0000_1000, 0, 2'd0, 8'h00, 0);
        check("R1 no entries", 32'h0, 1'b0, 3'd2);
        look(32'h1234_5678, 1, 2'd2, 8'h00, 1);
        check("R2 errlvl bypass", 32'h1234_5678, 1'b1, 3'd0);
        look(32'h8000_1234, 0, 2'd0, 8'h00, 0);
        check("R3 cached direct", 32'h0000_1234, 1'b1, 3'd0);
        look(32'hA040_0010, 1, 2'd0, 8'h00, 0);
        check("R3 uncached direct", 32'h0040_0010, 1'b1, 3'd0);
        look(32'h8000_0000, 0, 2'd2, 8'h00, 0);
        check("R3 user denied", 32'h0, 1'b0, 3'd1);
        look(32'hBFFF_FFFF, 0, 2'd1, 8'h00, 0);
        check("R3 super denied", 32'h0, 1'b0, 3'd1);

        load(4'd5, 19'h00401, 8'h12, 0, 20'h11111, 1, 1, 20'h22222, 1, 0);
        look(32'h0080_2ABC, 0, 2'd2, 8'h12, 0);
        check("R9 even hit", 32'h1111_1ABC, 1'b1, 3'd0);
        look(32'h0080_3ABC, 0, 2'd2, 8'h12, 0);
        check("R6 odd half", 32'h2222_2ABC, 1'b0, 3'd0);
        look(32'h0080_3ABC, 1, 2'd2, 8'h12, 0);
        check("R8 store clean", 32'h0, 1'b0, 3'd4);
        look(32'h0080_3ABC, 1, 2'd2, 8'h13, 0);
        check("R5 asid mismatch", 32'h0, 1'b0, 3'd2);
        look(32'h0080_2ABC, 0, 2'd2, 8'h12, 1);
        check("R2 errlvl over entry", 32'h0080_2ABC, 1'b1, 3'd0);

        load(4'd2, 19'h00401, 8'h77, 1, 20'h33333, 0, 1, 20'h44444, 1, 1);
        look(32'h0080_2000, 0, 2'd2, 8'h13, 0);
        check("R7 invalid global", 32'h0, 1'b0, 3'd3);
        look(32'h0080_2000, 0, 2'd2, 8'h12, 0);
        check("R10 lowest wins", 32'h0, 1'b0, 3'd3);
        look(32'h0080_3008, 1, 2'd2, 8'h12, 0);
        check("R10 lowest odd", 32'h4444_4008, 1'b1, 3'd0);

        load(4'd9, 19'h60002, 8'h00, 1, 20'hABCDE, 1, 1, 20'h0, 0, 0);
        look(32'hC000_4010, 0, 2'd1, 8'h55, 0);
        check("R4 super mapped", 32'hABCD_E010, 1'b1, 3'd0);
        look(32'hC000_4010, 0, 2'd3, 8'h55, 0);
        check("R4 user denied", 32'h0, 1'b0, 3'd1);
        look(32'hC000_5010, 0, 2'd0, 8'h55, 0);
        check("R7 odd invalid", 32'h0, 1'b0, 3'd3);
        load(4'd10, 19'h70000, 8'h00, 1, 20'h0, 0, 0, 20'h00042, 1, 1);
        look(32'hE000_1008, 1, 2'd0, 8'h00, 0);
        check("R4 kernel top", 32'h0004_2008, 1'b1, 3'd0);
        look(32'hE000_1008, 0, 2'd1, 8'h00, 0);
        check("R4 super top denied", 32'h0, 1'b0, 3'd1);
        look(32'hE000_3008, 0, 2'd0, 8'h00, 0);
        check("R11 miss clean", 32'h0, 1'b0, 3'd2);

        // same-cycle load sees old contents, next cycle sees new
        @(posedge clk); #1;
        lk_vaddr = 32'h0080_2ABC; lk_write = 0; lk_mode = 2'd2; lk_asid = 8'h12; lk_errlvl = 0;
        tw_en = 1; tw_idx = 4'd2; tw_vpn2 = 19'h00401; tw_asid = 8'h12; tw_global = 0;
        tw_pfn_even = 20'h55555; tw_valid_even = 1; tw_dirty_even = 0;
        tw_pfn_odd = 20'h0; tw_valid_odd = 0; tw_dirty_odd = 0;
        @(negedge clk);
        check("R12 old before edge", 32'h0, 1'b0, 3'd3);
        @(posedge clk); #1; tw_en = 0;
        @(negedge clk);
        check("R12 new after edge", 32'h5555_5ABC, 1'b0, 3'd0);

        // random loads and lookups, model compared each cycle
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #1;
            tw_en = ($urandom % 4) == 0;
            tw_idx = 4'($urandom);
            tw_vpn2 = {3'($urandom), 14'd0, 2'($urandom)};
            tw_asid = ($urandom % 2) ? 8'h12 : 8'h34;
            tw_global = ($urandom % 4) == 0;
            tw_pfn_even = 20'($urandom); tw_valid_even = ($urandom % 5) != 0;
            tw_dirty_even = 1'($urandom);
            tw_pfn_odd = 20'($urandom); tw_valid_odd = ($urandom % 5) != 0;
            tw_dirty_odd = 1'($urandom);
            lk_vaddr = {3'($urandom), 14'd0, 2'($urandom), 1'($urandom), 12'($urandom)};
            lk_write = 1'($urandom);
            lk_mode = 2'($urandom);
            lk_asid = ($urandom % 2) ? 8'h12 : 8'h34;
            lk_errlvl = ($urandom % 8) == 0;
        end
        @(posedge clk); #1; tw_en = 0;
        @(negedge clk);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule